// File: doc/BRIEF.md
# Masked Flash and Block Write Engine

This engine performs the two colour-fill operations of a row-organised memory array: a flash fill that paints every column of one row with the contents of a colour register, and a block fill that paints an aligned group of four columns. It does not decode raw strobes itself. An edge-detection stage ahead of it delivers one-cycle pulses for the falling edge of the row strobe and of the column strobe. With each pulse come the control-pin levels, the multiplexed address and the data pins as they stood at that edge.

Both fills honour a per-I/O-block write mask, which travels to the array as a bit-lane write-enable vector. A block fill also carries a per-column mask, which drives four parallel column write strobes. A flash fill walks the row one column per clock through the same write port and raises `busy` until the last column has been issued. New strobe events that arrive while `busy` is high are dropped.

Top module: `fill_engine`

## Requirements
- R1: After reset `busy` is 0. On any cycle where no fill write is issued, `wr_col_stb` and `wr_bit_en` are both 0.
- R2: A row-strobe fall is decoded as a flash fill when `ctl_col_hi`=1, `ctl_wen_hi`=0 and `ctl_fn_hi`=1. If the engine is idle, `busy` rises and column 0 is issued in the cycle after that edge.
- R3: A flash fill issues columns 0 to 2^ADDR_W-1 in ascending order, one per clock. `wr_grp` is the column's upper bits (col[7:2]) and `wr_col_stb` is one-hot with bit col[1:0] set. `busy` is high for exactly those 256 cycles and then falls.
- R4: During a flash fill `wr_bit_en` equals the data pins captured at the row-strobe fall (bit i = 1 writes I/O block i), and `wr_data` equals `colour`.
- R5: The row address is captured at the row-strobe fall and is held on `wr_row` for the whole operation, whatever `addr` does afterwards.
- R6: A row-strobe fall with `ctl_col_hi`=1, `ctl_xfer_hi`=1 and `ctl_fn_hi`=0 arms a block fill. A later column-strobe fall with `ctl_fn_hi`=1 issues exactly one block write, in the cycle after that edge.
- R7: The block group address `wr_grp` is `addr[7:2]` at the column-strobe fall. `addr[1:0]` has no effect.
- R8: In a block write `wr_col_stb[i]` equals data pin i at the column-strobe fall, and strobe i selects the column whose low address bits equal i.
- R9: In a block write `wr_bit_en` is the data pins captured at the row-strobe fall when `ctl_wen_hi` was 0 at that fall, and 4'b1111 when it was 1.
- R10: Row-strobe and column-strobe falls that arrive while `busy` is 1, including in the last flash cycle, are ignored. The row is unchanged, the sweep continues and no block write follows.
- R11: No write is issued for a column-strobe fall that has not been armed, for a column-strobe fall with `ctl_fn_hi`=0, or for a row-strobe fall that matches neither decode. When both strobe falls arrive in the same cycle, the row-strobe decode wins and any armed block is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_fall | input | 1 | One-cycle pulse: row strobe fell |
| col_fall | input | 1 | One-cycle pulse: column strobe fell |
| ctl_col_hi | input | 1 | Column strobe level at the row-strobe fall |
| ctl_wen_hi | input | 1 | Write-enable/mask-select level at the row-strobe fall |
| ctl_xfer_hi | input | 1 | Transfer/output-enable level at the row-strobe fall |
| ctl_fn_hi | input | 1 | Special-function select level at the current strobe fall |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq | input | IO_W | Data pins (I/O mask or column mask) |
| colour | input | IO_W | Colour register contents |
| busy | output | 1 | Flash sweep in progress |
| wr_row | output | ADDR_W | Row being written |
| wr_grp | output | ADDR_W-2 | Column group address (col[7:2]) |
| wr_col_stb | output | GRP | Per-column write strobes inside the group |
| wr_bit_en | output | IO_W | Per-I/O-block bit-lane write enable |
| wr_data | output | IO_W | Data written to every enabled lane |

## Verification
Two of the block's functions can meet in one cycle: the acceptance of a new row-strobe decode and the completion of the flash sweep, or the arming by a row-strobe fall and the firing by a column-strobe fall. The bench drives a flash decode with a different row into the last sweep cycle and judges that it is dropped: `busy` falls and the old row stays on `wr_row`. It then pulses both strobe falls together over an armed block and checks that a flash sweep of the new row starts with a one-hot column-0 strobe rather than a block write.

// File: rtl/fill_pkg.sv
package fill_pkg;

  typedef enum logic [1:0] {
    CYC_IGNORE    = 2'd0,
    CYC_FLASH     = 2'd1,
    CYC_BLOCK_ARM = 2'd2
  } cyc_kind_e;

  // Classify the control levels seen at a row-strobe fall.
  function automatic cyc_kind_e classify_row(input logic col_hi, input logic wen_hi,
                                             input logic xfer_hi, input logic fn_hi);
    if (col_hi && !wen_hi && fn_hi)
      return CYC_FLASH;
    else if (col_hi && xfer_hi && !fn_hi)
      return CYC_BLOCK_ARM;
    else
      return CYC_IGNORE;
  endfunction

endpackage

// File: rtl/fill_decode.sv
module fill_decode
  import fill_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IO_W   = 4,
  parameter int GRP    = 4,
  localparam int GRP_W = $clog2(GRP),
  localparam int GA_W  = ADDR_W - GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_fall,
  input  logic              col_fall,
  input  logic              ctl_col_hi,
  input  logic              ctl_wen_hi,
  input  logic              ctl_xfer_hi,
  input  logic              ctl_fn_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   dq,
  input  logic              busy,
  output logic              flash_go,
  output logic              blk_valid,
  output logic [ADDR_W-1:0] row_q,
  output logic [IO_W-1:0]   iomask_q,
  output logic [GA_W-1:0]   grp_q,
  output logic [GRP-1:0]    cmask_q
);

  cyc_kind_e kind;
  logic      row_accept;
  logic      col_accept;
  logic      blk_go;
  logic      armed;

  assign kind       = classify_row(ctl_col_hi, ctl_wen_hi, ctl_xfer_hi, ctl_fn_hi);
  assign row_accept = row_fall && !busy;
  // A row-strobe fall in the same cycle takes precedence over a column fall.
  assign col_accept = col_fall && !busy && !row_fall;
  assign flash_go   = row_accept && (kind == CYC_FLASH);
  assign blk_go     = col_accept && armed && ctl_fn_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      blk_valid <= 1'b0;
      row_q     <= '0;
      iomask_q  <= '0;
      grp_q     <= '0;
      cmask_q   <= '0;
    end else begin
      blk_valid <= blk_go;
      if (row_accept) begin
        row_q    <= addr;
        armed    <= (kind == CYC_BLOCK_ARM);
        // Flash always masks; block masks only with the write-enable pin low.
        iomask_q <= (kind == CYC_BLOCK_ARM && ctl_wen_hi) ? {IO_W{1'b1}} : dq;
      end else if (col_accept) begin
        armed <= 1'b0;
      end
      if (blk_go) begin
        grp_q   <= addr[ADDR_W-1:GRP_W];
        cmask_q <= dq[GRP-1:0];
      end
    end
  end

endmodule

// File: rtl/fill_sweep.sv
module fill_sweep #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_go,
  output logic              active,
  output logic [ADDR_W-1:0] col
);

  logic last_col;
  assign last_col = (col == {ADDR_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      col    <= '0;
    end else if (active) begin
      if (last_col) begin
        active <= 1'b0;
        col    <= '0;
      end else begin
        col <= col + 1'b1;
      end
    end else if (flash_go) begin
      active <= 1'b1;
      col    <= '0;
    end
  end

endmodule

// File: rtl/fill_wport.sv
module fill_wport #(
  parameter int ADDR_W = 8,
  parameter int IO_W   = 4,
  parameter int GRP    = 4,
  localparam int GRP_W = $clog2(GRP),
  localparam int GA_W  = ADDR_W - GRP_W
) (
  input  logic              sweep_on,
  input  logic [ADDR_W-1:0] sweep_col,
  input  logic              blk_valid,
  input  logic [IO_W-1:0]   iomask_q,
  input  logic [GA_W-1:0]   grp_q,
  input  logic [GRP-1:0]    cmask_q,
  output logic [GA_W-1:0]   wr_grp,
  output logic [GRP-1:0]    wr_col_stb,
  output logic [IO_W-1:0]   wr_bit_en
);

  function automatic logic [GRP-1:0] lane_onehot(input logic [GRP_W-1:0] idx);
    logic [GRP-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  always_comb begin
    wr_grp     = '0;
    wr_col_stb = '0;
    wr_bit_en  = '0;
    if (sweep_on) begin
      wr_grp     = sweep_col[ADDR_W-1:GRP_W];
      wr_col_stb = lane_onehot(sweep_col[GRP_W-1:0]);
      wr_bit_en  = iomask_q;
    end else if (blk_valid) begin
      wr_grp     = grp_q;
      wr_col_stb = cmask_q;
      wr_bit_en  = iomask_q;
    end
  end

endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
  parameter int ADDR_W = 8,
  parameter int IO_W   = 4,
  parameter int GRP    = 4,
  localparam int GRP_W = $clog2(GRP),
  localparam int GA_W  = ADDR_W - GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_fall,
  input  logic              col_fall,
  input  logic              ctl_col_hi,
  input  logic              ctl_wen_hi,
  input  logic              ctl_xfer_hi,
  input  logic              ctl_fn_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   dq,
  input  logic [IO_W-1:0]   colour,
  output logic              busy,
  output logic [ADDR_W-1:0] wr_row,
  output logic [GA_W-1:0]   wr_grp,
  output logic [GRP-1:0]    wr_col_stb,
  output logic [IO_W-1:0]   wr_bit_en,
  output logic [IO_W-1:0]   wr_data
);

  // Named internal events for the bound checker.
  logic              flash_go;
  logic              blk_valid;
  logic [ADDR_W-1:0] flash_col;
  logic [ADDR_W-1:0] row_q;
  logic [IO_W-1:0]   iomask_q;
  logic [GA_W-1:0]   grp_q;
  logic [GRP-1:0]    cmask_q;

  fill_decode #(.ADDR_W(ADDR_W), .IO_W(IO_W), .GRP(GRP)) u_dec (
    .clk(clk), .rst_n(rst_n), .row_fall(row_fall), .col_fall(col_fall),
    .ctl_col_hi(ctl_col_hi), .ctl_wen_hi(ctl_wen_hi), .ctl_xfer_hi(ctl_xfer_hi),
    .ctl_fn_hi(ctl_fn_hi), .addr(addr), .dq(dq), .busy(busy),
    .flash_go(flash_go), .blk_valid(blk_valid), .row_q(row_q),
    .iomask_q(iomask_q), .grp_q(grp_q), .cmask_q(cmask_q)
  );

  fill_sweep #(.ADDR_W(ADDR_W)) u_swp (
    .clk(clk), .rst_n(rst_n), .flash_go(flash_go), .active(busy), .col(flash_col)
  );

  fill_wport #(.ADDR_W(ADDR_W), .IO_W(IO_W), .GRP(GRP)) u_wp (
    .sweep_on(busy), .sweep_col(flash_col), .blk_valid(blk_valid),
    .iomask_q(iomask_q), .grp_q(grp_q), .cmask_q(cmask_q),
    .wr_grp(wr_grp), .wr_col_stb(wr_col_stb), .wr_bit_en(wr_bit_en)
  );

  assign wr_row  = row_q;
  assign wr_data = colour;

endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
  parameter int ADDR_W = 8,
  parameter int IO_W   = 4,
  parameter int GRP    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              flash_go,
  input logic              blk_valid,
  input logic [ADDR_W-1:0] flash_col,
  input logic [ADDR_W-1:0] wr_row,
  input logic [GRP-1:0]    wr_col_stb,
  input logic [IO_W-1:0]   wr_bit_en
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !blk_valid) |-> (wr_col_stb == '0 && wr_bit_en == '0));

  assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (flash_col == ADDR_W'($past(flash_col) + 1'b1)));

  assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(wr_col_stb) == 1));

  assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wr_row));

  assert_blk_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |=> !blk_valid);

  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flash_go |-> !busy);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !busy);

endmodule

bind fill_engine fill_engine_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W), .GRP(GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .flash_go(flash_go), .blk_valid(blk_valid),
  .flash_col(flash_col), .wr_row(wr_row), .wr_col_stb(wr_col_stb), .wr_bit_en(wr_bit_en)
);

// File: tb/sim_fill_engine.sv
module sim_fill_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_fall = 1'b0, col_fall = 1'b0;
  logic       ctl_col_hi = 1'b0, ctl_wen_hi = 1'b0, ctl_xfer_hi = 1'b0, ctl_fn_hi = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] dq = '0, colour = '0;
  logic       busy;
  logic [7:0] wr_row;
  logic [5:0] wr_grp;
  logic [3:0] wr_col_stb, wr_bit_en, wr_data;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fill_engine u0 (.*);

  typedef struct packed {
    logic       wen;    // write-enable level at row fall
    logic [7:0] row;
    logic [3:0] rdq;    // data pins at row fall
    logic [7:0] cad;    // address at column fall
    logic [3:0] cdq;    // data pins at column fall
    logic       fn_c;   // function select at column fall
    logic [3:0] e_stb;
    logic [3:0] e_en;
    logic [5:0] e_grp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 8'h11, 4'b1010, 8'h07, 4'b1111, 1'b1, 4'b1111, 4'b1010, 6'd1},
    '{1'b1, 8'hFE, 4'b0000, 8'hFF, 4'b0101, 1'b1, 4'b0101, 4'b1111, 6'd63},
    '{1'b0, 8'h00, 4'b0001, 8'h80, 4'b1000, 1'b1, 4'b1000, 4'b0001, 6'd32},
    '{1'b0, 8'h42, 4'b1111, 8'h43, 4'b0000, 1'b1, 4'b0000, 4'b1111, 6'd16},
    '{1'b0, 8'h55, 4'b0110, 8'h3C, 4'b0110, 1'b0, 4'b0000, 4'b0000, 6'd0},
    '{1'b1, 8'h9A, 4'b0110, 8'h3D, 4'b0110, 1'b1, 4'b0110, 4'b1111, 6'd15}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Pulse a row-strobe fall; returns at the negedge after the capturing edge.
  task automatic row_ev(input logic c, input logic w, input logic x, input logic f,
                        input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    ctl_col_hi = c; ctl_wen_hi = w; ctl_xfer_hi = x; ctl_fn_hi = f;
    addr = a; dq = d; row_fall = 1'b1;
    @(negedge clk);
    row_fall = 1'b0; addr = ~a;
  endtask

  task automatic col_ev(input logic f, input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    ctl_fn_hi = f; addr = a; dq = d; col_fall = 1'b1;
    @(negedge clk);
    col_fall = 1'b0; addr = ~a;
  endtask

  // Full flash sweep check starting at the first column's negedge.
  task automatic sweep_chk(input logic [7:0] row, input logic [3:0] msk, input bit inject);
    for (int c = 0; c < 256; c++) begin
      chk("R3 busy", busy, 1);
      chk("R3 grp", wr_grp, c >> 2);
      chk("R3 stb", wr_col_stb, 4'b0001 << (c % 4));
      chk("R4 en", wr_bit_en, msk);
      chk("R4 data", wr_data, colour);
      chk("R5 row", wr_row, row);
      row_fall = 1'b0; col_fall = 1'b0;
      if (inject && (c == 100 || c == 255)) begin
        ctl_col_hi = 1; ctl_wen_hi = 0; ctl_fn_hi = 1; addr = 8'h99; dq = 4'b0100;
        row_fall = 1'b1;          // R10: ignored while busy
      end else if (inject && c == 150) begin
        ctl_fn_hi = 1; addr = 8'h20; dq = 4'b1111; col_fall = 1'b1;
      end
      @(negedge clk);
    end
    row_fall = 1'b0; col_fall = 1'b0;
    chk("R3 busy falls", busy, 0);
    chk("R10 no new start", wr_col_stb, 0);
    chk("R10 row kept", wr_row, row);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset stb", wr_col_stb, 0);
    chk("R1 reset en", wr_bit_en, 0);
    rst_n = 1'b1;
    colour = 4'b1001;

    // Block fill vectors (R6 R7 R8 R9 R11)
    foreach (VEC[i]) begin
      row_ev(1'b1, VEC[i].wen, 1'b1, 1'b0, VEC[i].row, VEC[i].rdq);
      chk("R6 armed idle", wr_col_stb, 0);
      col_ev(VEC[i].fn_c, VEC[i].cad, VEC[i].cdq);
      chk("R8 stb", wr_col_stb, VEC[i].e_stb);
      chk("R9 en", wr_bit_en, VEC[i].e_en);
      chk("R7 grp", wr_grp, VEC[i].e_grp);
      chk("R5 row", wr_row, VEC[i].row);
      chk("R1 busy", busy, 0);
      @(negedge clk);
      chk("R6 one cycle", wr_col_stb, 0);
      // Second column fall without re-arming: nothing written (R11)
      col_ev(1'b1, VEC[i].cad, 4'b1111);
      chk("R11 unarmed", wr_col_stb, 0);
    end

    // Flash with injections (R2 R3 R4 R5 R10)
    colour = 4'b0110;
    row_ev(1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 4'b1011);
    sweep_chk(8'h3C, 4'b1011, 1'b1);

    // Flash with all I/O masked, xfer level high (R2 R4)
    colour = 4'b1111;
    row_ev(1'b1, 1'b0, 1'b1, 1'b1, 8'hC3, 4'b0000);
    sweep_chk(8'hC3, 4'b0000, 1'b0);

    // Non-matching row decodes then column fall (R11)
    row_ev(1'b0, 1'b0, 1'b1, 1'b1, 8'h12, 4'b1111);
    chk("R11 col low no start", busy, 0);
    row_ev(1'b1, 1'b1, 1'b0, 1'b1, 8'h13, 4'b1111);
    chk("R11 wen high no start", busy, 0);
    col_ev(1'b1, 8'h40, 4'b1111);
    chk("R11 no block", wr_col_stb, 0);

    // Same-cycle strobes over an armed block: row decode wins (R11)
    row_ev(1'b1, 1'b0, 1'b1, 1'b0, 8'h21, 4'b1111);
    @(negedge clk);
    ctl_col_hi = 1; ctl_wen_hi = 0; ctl_xfer_hi = 1; ctl_fn_hi = 1;
    addr = 8'h77; dq = 4'b0011; row_fall = 1'b1; col_fall = 1'b1;
    @(negedge clk);
    row_fall = 1'b0; col_fall = 1'b0;
    chk("R11 same-cycle flash", busy, 1);
    chk("R11 same-cycle stb", wr_col_stb, 4'b0001);
    chk("R11 same-cycle row", wr_row, 8'h77);
    chk("R11 same-cycle en", wr_bit_en, 4'b0011);
    repeat (256) @(negedge clk);
    chk("R3 drained", busy, 0);
    chk("R11 no late block", wr_col_stb, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule